// File: doc/BRIEF.md
# Supply-Dip Reset Filter Controller

This block is the digital half of a low-supply monitor. An analog comparator outside the block reports whether the supply sits below the selected trip level. The block re-times that bit through a short synchronizer and shows it as a status flag. It counts how long a dip lasts, and it raises a reset request only when the dip is sustained. Once the reset is raised, the block tells the analog side to compare against a raised release level. It drops the reset as soon as one synchronized sample shows the supply above that level.

Three configuration bits control it. A monitor enable gates everything. A reset enable decides whether a qualified dip becomes a reset or only shows on the status flag. A range select is passed through to the comparator to choose one of two trip and hysteresis pairs. The reset request also drives an open-drain style pin output, so parts outside the chip are held in reset as well. Monitoring works straight out of power-on reset, using whatever the configuration pins present.

Top module: `supply_dip_guard`

## Requirements
- R1: While `rst` is high and on the first sample after it, `rst_req_o`, `rst_pin_pull_o`, `lvl_raise_o` and `status_low_o` are all 0.
- R2: `status_low_o` equals the value of `cmp_low_i` (1 = supply below trip) captured two clock edges earlier, ANDed with `cfg_mon_en`. It is not filtered.
- R3: When `cmp_low_i` is 1 for nine or more consecutive cycles, with both enables set, `rst_req_o` rises at the tenth clock edge after the edge that first captured the low level.
- R4: A low run of eight cycles or fewer never raises `rst_req_o`. A single high cycle restarts the count, so runs of 5 and 8 separated by one high cycle cause no reset.
- R5: Once raised, `rst_req_o` stays 1 while the input stays low. It falls at the second edge after the edge that captures the first high value.
- R6: One high cycle is enough to release the reset. A fresh run of nine lows is then needed to raise it again.
- R7: With `cfg_mon_en` = 0, `status_low_o` is 0 and `rst_req_o` never rises, whatever `cmp_low_i` does.
- R8: With `cfg_rst_en` = 0 and `cfg_mon_en` = 1, the status flag still follows the input, but `rst_req_o` stays 0.
- R9: `rst_pin_pull_o` (1 = pull the reset pin low) and `lvl_raise_o` (1 = compare against the raised release level) are 1 exactly when `rst_req_o` is 1.
- R10: `range_sel_o` equals `cfg_range_sel` in the same cycle.
- R11: The run counter saturates. A dip of 40 cycles keeps `rst_req_o` at 1 without a break until the input returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cmp_low_i | input | 1 | Comparator result, 1 = supply below the active level |
| cfg_mon_en | input | 1 | Monitor enable |
| cfg_rst_en | input | 1 | Allow a qualified dip to request reset |
| cfg_range_sel | input | 1 | Trip/hysteresis pair select |
| rst_req_o | output | 1 | Reset request |
| rst_pin_pull_o | output | 1 | Open-drain style drive, 1 = pull reset pin low |
| status_low_o | output | 1 | Synchronized raw comparator flag |
| lvl_raise_o | output | 1 | 1 = analog side uses the raised release level |
| range_sel_o | output | 1 | Range select passed to the analog side |

## Verification
The main stimulus is a sweep of single low pulses of every length from 1 to 14 cycles, plus a 40-cycle pulse, under all four combinations of the two enables. This separates the eight-cycle pulse, which must be rejected, from the nine-cycle pulse, which must qualify. It also pins the exact rise and fall edges and shows the enables masking the result. A broken run of 5 + 8 lows tells a counter that clears on a high sample from one that only pauses. A one-cycle high gap inside a held reset shows that a single sample releases the reset and that the next reset needs a full new run. The 40-cycle pulse exposes a counter that wraps instead of saturating.

// File: rtl/sdg_pkg.sv
package sdg_pkg;

    typedef struct packed {
        logic mon_en;
        logic rst_en;
        logic range_sel;
    } sdg_cfg_t;

    typedef enum logic {
        HOLD_IDLE   = 1'b0,
        HOLD_ACTIVE = 1'b1
    } sdg_hold_e;

    function automatic int cnt_width(input int qual);
        return $clog2(qual + 1);
    endfunction

endpackage

// File: rtl/sdg_sync.sv
module sdg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sdg_dip_filter.sv
module sdg_dip_filter #(
    parameter int QUAL = 9
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic low,
    output logic qualify
);
    localparam int CW = sdg_pkg::cnt_width(QUAL);
    localparam logic [CW-1:0] LAST = CW'(QUAL - 1);
    localparam logic [CW-1:0] TOP  = CW'(QUAL);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)                 run_q <= '0;
        else if (!enable || !low) run_q <= '0;
        else if (run_q != TOP)   run_q <= run_q + 1'b1;
    end

    // the current low sample completes (or extends) a qualifying run
    assign qualify = enable && low && (run_q >= LAST);
endmodule

// File: rtl/sdg_hold_ctrl.sv
module sdg_hold_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic qualify,
    input  logic low,
    output logic held
);
    import sdg_pkg::*;

    sdg_hold_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            HOLD_IDLE:   if (arm && qualify) st_d = HOLD_ACTIVE;
            HOLD_ACTIVE: if (!arm || !low)   st_d = HOLD_IDLE;
            default:     st_d = HOLD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= HOLD_IDLE;
        else     st_q <= st_d;
    end

    assign held = (st_q == HOLD_ACTIVE);
endmodule

// File: rtl/supply_dip_guard.sv
module supply_dip_guard #(
    parameter int QUAL_CYCLES = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cmp_low_i,
    input  logic cfg_mon_en,
    input  logic cfg_rst_en,
    input  logic cfg_range_sel,
    output logic rst_req_o,
    output logic rst_pin_pull_o,
    output logic status_low_o,
    output logic lvl_raise_o,
    output logic range_sel_o
);
    import sdg_pkg::*;

    sdg_cfg_t cfg;
    logic     low_s;
    logic     qual;
    logic     held;

    assign cfg = '{mon_en: cfg_mon_en, rst_en: cfg_rst_en, range_sel: cfg_range_sel};

    sdg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (cmp_low_i),
        .q   (low_s)
    );

    sdg_dip_filter #(.QUAL(QUAL_CYCLES)) u_filter (
        .clk     (clk),
        .rst     (rst),
        .enable  (cfg.mon_en),
        .low     (low_s),
        .qualify (qual)
    );

    sdg_hold_ctrl u_hold (
        .clk     (clk),
        .rst     (rst),
        .arm     (cfg.mon_en && cfg.rst_en),
        .qualify (qual),
        .low     (low_s),
        .held    (held)
    );

    assign rst_req_o      = held;
    assign rst_pin_pull_o = held;
    assign lvl_raise_o    = held;
    assign status_low_o   = low_s && cfg.mon_en;
    assign range_sel_o    = cfg.range_sel;
endmodule

// File: rtl/supply_dip_guard_chk.sv
module supply_dip_guard_chk #(
    parameter int QUAL_CYCLES = 9
) (
    input logic clk,
    input logic rst,
    input logic cfg_mon_en,
    input logic cfg_rst_en,
    input logic rst_req_o,
    input logic status_low_o
);
    localparam int RW = $clog2(QUAL_CYCLES + 1);
    localparam logic [RW-1:0] RTOP = RW'(QUAL_CYCLES);

    logic [RW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst)               low_run <= '0;
        else if (!status_low_o) low_run <= '0;
        else if (low_run != RTOP) low_run <= low_run + 1'b1;
    end

    // R3
    rise_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req_o) |-> (low_run == RTOP));

    // R2
    rise_after_status_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req_o) |-> $past(status_low_o));

    // R5
    release_one_sample_chk: assert property (@(posedge clk) disable iff (rst)
        (rst_req_o && !status_low_o) |=> !rst_req_o);

    // R7
    mon_off_no_reset_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_mon_en |=> !rst_req_o);

    // R8
    rst_en_off_no_reset_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_rst_en |=> !rst_req_o);
endmodule

bind supply_dip_guard supply_dip_guard_chk #(.QUAL_CYCLES(QUAL_CYCLES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_mon_en   (cfg_mon_en),
    .cfg_rst_en   (cfg_rst_en),
    .rst_req_o    (rst_req_o),
    .status_low_o (status_low_o)
);

// File: tb/supply_dip_guard_tb_top.sv
module supply_dip_guard_tb_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmp_low_i = 1'b0;
    logic cfg_mon_en = 1'b1;
    logic cfg_rst_en = 1'b1;
    logic cfg_range_sel = 1'b0;
    logic rst_req_o, rst_pin_pull_o, status_low_o, lvl_raise_o, range_sel_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    supply_dip_guard dut_i (
        .clk            (clk),
        .rst            (rst),
        .cmp_low_i      (cmp_low_i),
        .cfg_mon_en     (cfg_mon_en),
        .cfg_rst_en     (cfg_rst_en),
        .cfg_range_sel  (cfg_range_sel),
        .rst_req_o      (rst_req_o),
        .rst_pin_pull_o (rst_pin_pull_o),
        .status_low_o   (status_low_o),
        .lvl_raise_o    (lvl_raise_o),
        .range_sel_o    (range_sel_o)
    );

    task automatic chk(input string req, input logic act, input logic exp, input int cyc);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %b expected %b", req, cyc, act, exp);
        end
    endtask

    // reset with the given enables; returns at a falling edge with cmp set for edge 0
    task automatic do_reset(input logic mon, input logic en, input logic first_low);
        @(negedge clk);
        rst = 1'b1;
        cfg_mon_en = mon;
        cfg_rst_en = en;
        cmp_low_i = 1'b1;
        repeat (2) @(negedge clk);
        // R1: outputs quiet during reset
        chk("R1", rst_req_o, 1'b0, -1);
        chk("R1", status_low_o, 1'b0, -1);
        rst = 1'b0;
        cmp_low_i = first_low;
    endtask

    // single low pulse of length len starting at edge 0
    task automatic pulse_trial(input logic mon, input logic en, input int len);
        bit fires;
        do_reset(mon, en, len > 0);
        fires = mon && en && (len >= 9);
        for (int k = 0; k < len + 6; k++) begin
            bit exp_req, exp_st;
            @(negedge clk);
            exp_st  = mon && (k >= 1) && (k <= len);
            exp_req = fires && (k >= 10) && (k <= len + 1);
            if (k == 0) chk("R1", rst_req_o, 1'b0, k);
            chk(mon ? "R2" : "R7", status_low_o, exp_st, k);
            if (!mon)          chk("R7", rst_req_o, exp_req, k);
            else if (!en)      chk("R8", rst_req_o, exp_req, k);
            else if (len < 9)  chk("R4", rst_req_o, exp_req, k);
            else if (k <= 10)  chk("R3", rst_req_o, exp_req, k);
            else if (len > 16) chk("R11", rst_req_o, exp_req, k);
            else               chk("R5", rst_req_o, exp_req, k);
            chk("R9", rst_pin_pull_o, exp_req, k);
            chk("R9", lvl_raise_o, exp_req, k);
            cmp_low_i = (k + 1 < len);
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: pass-through of range select
        for (int v = 0; v < 2; v++) begin
            @(negedge clk);
            cfg_range_sel = v[0];
            #1;
            chk("R10", range_sel_o, v[0], v);
        end

        // sweep of pulse lengths under every enable pair
        for (int m = 0; m < 4; m++) begin
            for (int len = 1; len <= 14; len++) pulse_trial(m[1], m[0], len);
            pulse_trial(m[1], m[0], 40);
        end

        // R4: 5 lows, 1 high, 8 lows -> count restarts, no reset
        do_reset(1'b1, 1'b1, 1'b1);
        for (int k = 0; k < 25; k++) begin
            @(negedge clk);
            chk("R4", rst_req_o, 1'b0, k);
            cmp_low_i = ((k + 1) < 5) || (((k + 1) >= 6) && ((k + 1) < 14));
        end

        // R6: held reset, one high cycle at edge 12, low again from edge 13
        do_reset(1'b1, 1'b1, 1'b1);
        for (int k = 0; k < 30; k++) begin
            bit exp_req;
            @(negedge clk);
            exp_req = ((k >= 10) && (k <= 13)) || (k >= 23);
            chk("R6", rst_req_o, exp_req, k);
            cmp_low_i = ((k + 1) != 12);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule